// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

After reset this block brings one DDR SDRAM rank from power-on to operation. It owns the command/address bus toward a PHY or command encoder. It waits a programmable number of microsecond ticks for the supply and clock to settle. It then issues a fixed series of commands with a programmable number of idle cycles between them:

- no-operation
- precharge of all banks
- a write of zero to the extended mode register, which enables the DLL
- a mode register write with DLL reset selected
- a second wait measured in ticks
- a second precharge of all banks
- a programmable number of auto-refresh cycles
- a final mode register write in normal operating mode

The mode register word is built from parameters for burst length, burst type and CAS latency. When the last write has been issued, the block pulses a resync of the receive-FIFO pointers for one cycle. On the next cycle it raises `init_done_o` and `refresh_en_o`, and it keeps both high until reset. From then on it forwards command requests from the controller, one cycle later. Any request that arrives before that point is dropped.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_ni` is low, and after reset, the outputs are as follows: `cmd_o` = 1 (NOP), `cmd_stb_o` = 0, `addr_o` = 0, `ba_o` = 0, `fifo_rst_o` = 0, `init_done_o` = 0, `refresh_en_o` = 0.
- R2: `cmd_o` uses this 3-bit code: 0 self refresh, 1 NOP, 2 precharge all, 3 mode register set, 4 extended mode register set, 6 auto refresh, 7 normal operation. Code 5 is reserved and is never driven.
- R3: The first command strobe appears only after PWR_WAIT_US (default 200) ticks of `us_tick_i` have been counted since reset was released.
- R4: The sequence consists of exactly 14 strobed commands, in this order: NOP, precharge, extended mode set, mode set (DLL reset), precharge, REFRESH_COUNT (default 8) auto refreshes, mode set (normal).
- R5: The mode word in `addr_o` has burst length in bits [2:0] (1=2, 2=4, 3=8), burst type in bit 3 (1 = interleaved), CAS code in bits [6:4] (2=2.0, 3=3.0, 5=1.5, 6=2.5) and operating mode in bits [8:7] (0 normal, 2 DLL reset). With the defaults the DLL-reset word is 0x12A and the normal word is 0x02A. Mode set commands use `ba_o` = 0. The extended mode set uses `ba_o` = 1 with address 0. Precharge drives bit 10 of the address (0x400). Refresh and NOP drive address 0.
- R6: Between the DLL-reset mode write and the following precharge, at least DLL_WAIT_US (default 200) ticks pass, and no more than one extra tick.
- R7: Each sequence command is strobed for one cycle. It is followed by GAP_CYCLES (default 2) cycles of NOP with the strobe low before the next command, unless a tick wait comes between them.
- R8: `fifo_rst_o` is high for exactly one cycle, GAP_CYCLES+1 cycles after the strobe of the final mode write.
- R9: `init_done_o` and `refresh_en_o` rise together on the cycle after the FIFO resync pulse and stay high until reset.
- R10: Before `init_done_o`, requests on `req_valid_i` are ignored. They add no strobe and change no command.
- R11: After `init_done_o`, a request is driven on `cmd_o`/`addr_o`/`ba_o` with `cmd_stb_o` high one cycle later. With no request, `cmd_o` shows 7 (normal) and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-cycle pulse, once per microsecond |
| req_valid_i | input | 1 | Controller command request |
| req_cmd_i | input | 3 | Requested command code |
| req_ba_i | input | 2 | Requested bank address |
| req_addr_i | input | ADDR_W | Requested address |
| cmd_o | output | 3 | Command code toward the PHY |
| cmd_stb_o | output | 1 | High for a cycle when a command is issued |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address / mode word |
| fifo_rst_o | output | 1 | Receive-FIFO pointer resync pulse |
| init_done_o | output | 1 | Initialization complete, held until reset |
| refresh_en_o | output | 1 | Periodic refresh enabled |

## Verification
Two things can meet in one cycle: a controller request, and a scheduled sequence command or the hand-over to normal mode. The bench drives a request every fifth cycle for the whole sequence, including the cycle on which `fifo_rst_o` is high and the cycle before `init_done_o`. It then requires that the recorded command stream is exactly the 14-entry table, with each gap matching. A second collision is a tick that arrives on the same edge as a gap edge after the DLL-reset write. For this reason the DLL window is judged against a band of one tick rather than an exact count.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_SELF_REF = 3'd0,
    CMD_NOP      = 3'd1,
    CMD_PRE_ALL  = 3'd2,
    CMD_MRS      = 3'd3,
    CMD_EMRS     = 3'd4,
    CMD_RSVD     = 3'd5,
    CMD_REFRESH  = 3'd6,
    CMD_NORMAL   = 3'd7
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    STP_NOP,
    STP_PRE1,
    STP_EMRS,
    STP_MRS_DLL,
    STP_PRE2,
    STP_REF,
    STP_MRS_NORM
  } ddr_step_e;

  localparam logic [1:0] OPM_NORMAL  = 2'd0;
  localparam logic [1:0] OPM_TEST    = 2'd1;
  localparam logic [1:0] OPM_DLL_RST = 2'd2;

  function automatic logic [8:0] mode_word(input logic [2:0] bl, input logic bt,
                                           input logic [2:0] cl, input logic [1:0] opm);
    return {opm, cl, bt, bl};
  endfunction

endpackage

// File: rtl/ddr_init_us_timer.sv
module ddr_init_us_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!arm_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // fires on the limit-th tick while armed
  assign done_o = arm_i && tick_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter logic [2:0]  BL_CODE = 3'd2,
  parameter logic        BT_ILV  = 1'b1,
  parameter logic [2:0]  CL_CODE = 3'd2
) (
  output logic [ADDR_W-1:0] mr_norm_o,
  output logic [ADDR_W-1:0] mr_dll_o
);
  assign mr_norm_o = ADDR_W'(mode_word(BL_CODE, BT_ILV, CL_CODE, OPM_NORMAL));
  assign mr_dll_o  = ADDR_W'(mode_word(BL_CODE, BT_ILV, CL_CODE, OPM_DLL_RST));
endmodule

// File: rtl/ddr_init_step_dec.sv
module ddr_init_step_dec
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  ddr_step_e         step_i,
  input  logic [ADDR_W-1:0] mr_norm_i,
  input  logic [ADDR_W-1:0] mr_dll_i,
  output ddr_cmd_e          cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] pre_all_addr;

  generate
    if (ADDR_W > 10) begin : g_a10
      assign pre_all_addr = ADDR_W'(1) << 10;
    end else begin : g_no_a10
      assign pre_all_addr = '0;
    end
  endgenerate

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'd0;
    addr_o = '0;
    unique case (step_i)
      STP_NOP:      cmd_o = CMD_NOP;
      STP_PRE1,
      STP_PRE2:     begin cmd_o = CMD_PRE_ALL; addr_o = pre_all_addr; end
      STP_EMRS:     begin cmd_o = CMD_EMRS; ba_o = 2'd1; end
      STP_MRS_DLL:  begin cmd_o = CMD_MRS; addr_o = mr_dll_i; end
      STP_REF:      cmd_o = CMD_REFRESH;
      STP_MRS_NORM: begin cmd_o = CMD_MRS; addr_o = mr_norm_i; end
      default:      cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W        = 13,
  parameter int         PWR_WAIT_US   = 200,
  parameter int         DLL_WAIT_US   = 200,
  parameter int         GAP_CYCLES    = 2,
  parameter int         REFRESH_COUNT = 8,
  parameter logic [2:0] BL_CODE       = 3'd2,
  parameter logic       BT_ILV        = 1'b1,
  parameter logic [2:0] CL_CODE       = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_cmd_i,
  input  logic [1:0]        req_ba_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [2:0]        cmd_o,
  output logic              cmd_stb_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fifo_rst_o,
  output logic              init_done_o,
  output logic              refresh_en_o
);
  localparam int WAIT_MAX = (PWR_WAIT_US > DLL_WAIT_US) ? PWR_WAIT_US : DLL_WAIT_US;
  localparam int TMR_W    = $clog2(WAIT_MAX + 1);
  localparam int GAP_W    = $clog2(GAP_CYCLES + 1);
  localparam int REF_W    = $clog2(REFRESH_COUNT + 1);

  typedef enum logic [2:0] {
    ST_WAIT_PWR, ST_ISSUE, ST_GAP, ST_WAIT_DLL, ST_FIFO_HI, ST_FIFO_LO, ST_DONE
  } st_e;

  st_e               st_q;
  ddr_step_e         step_q;
  logic [GAP_W-1:0]  gap_q;
  logic [REF_W-1:0]  ref_q;
  ddr_cmd_e          cmd_q;
  logic              stb_q, fifo_q, done_q, ref_en_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;

  logic              tmr_arm, tmr_done;
  logic [TMR_W-1:0]  tmr_limit;
  logic [ADDR_W-1:0] mr_norm, mr_dll, dec_addr;
  ddr_cmd_e          dec_cmd;
  logic [1:0]        dec_ba;

  assign tmr_arm   = (st_q == ST_WAIT_PWR) || (st_q == ST_WAIT_DLL);
  assign tmr_limit = (st_q == ST_WAIT_PWR) ? TMR_W'(PWR_WAIT_US) : TMR_W'(DLL_WAIT_US);

  ddr_init_us_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (tmr_arm),
    .tick_i  (us_tick_i),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  ddr_init_mode_word #(
    .ADDR_W(ADDR_W), .BL_CODE(BL_CODE), .BT_ILV(BT_ILV), .CL_CODE(CL_CODE)
  ) u_mode (
    .mr_norm_o (mr_norm),
    .mr_dll_o  (mr_dll)
  );

  ddr_init_step_dec #(.ADDR_W(ADDR_W)) u_dec (
    .step_i    (step_q),
    .mr_norm_i (mr_norm),
    .mr_dll_i  (mr_dll),
    .cmd_o     (dec_cmd),
    .ba_o      (dec_ba),
    .addr_o    (dec_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_WAIT_PWR;
      step_q   <= STP_NOP;
      gap_q    <= '0;
      ref_q    <= '0;
      cmd_q    <= CMD_NOP;
      stb_q    <= 1'b0;
      ba_q     <= 2'd0;
      addr_q   <= '0;
      fifo_q   <= 1'b0;
      done_q   <= 1'b0;
      ref_en_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_WAIT_PWR,
        ST_WAIT_DLL: if (tmr_done) st_q <= ST_ISSUE;
        ST_ISSUE: begin
          cmd_q  <= dec_cmd;
          ba_q   <= dec_ba;
          addr_q <= dec_addr;
          stb_q  <= 1'b1;
          gap_q  <= '0;
          st_q   <= ST_GAP;
        end
        ST_GAP: begin
          cmd_q  <= CMD_NOP;
          ba_q   <= 2'd0;
          addr_q <= '0;
          stb_q  <= 1'b0;
          if (gap_q == GAP_W'(GAP_CYCLES - 1)) begin
            st_q <= ST_ISSUE;
            unique case (step_q)
              STP_NOP:     step_q <= STP_PRE1;
              STP_PRE1:    step_q <= STP_EMRS;
              STP_EMRS:    step_q <= STP_MRS_DLL;
              STP_MRS_DLL: begin step_q <= STP_PRE2; st_q <= ST_WAIT_DLL; end
              STP_PRE2:    begin step_q <= STP_REF; ref_q <= '0; end
              STP_REF: begin
                if (ref_q == REF_W'(REFRESH_COUNT - 1)) step_q <= STP_MRS_NORM;
                else ref_q <= ref_q + 1'b1;
              end
              STP_MRS_NORM: st_q <= ST_FIFO_HI;
              default:      st_q <= ST_FIFO_HI;
            endcase
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_FIFO_HI: begin
          fifo_q <= 1'b1;
          st_q   <= ST_FIFO_LO;
        end
        ST_FIFO_LO: begin
          fifo_q   <= 1'b0;
          done_q   <= 1'b1;
          ref_en_q <= 1'b1;
          cmd_q    <= CMD_NORMAL;
          st_q     <= ST_DONE;
        end
        ST_DONE: begin
          stb_q  <= req_valid_i;
          cmd_q  <= req_valid_i ? ddr_cmd_e'(req_cmd_i) : CMD_NORMAL;
          ba_q   <= req_valid_i ? req_ba_i : 2'd0;
          addr_q <= req_valid_i ? req_addr_i : '0;
        end
        default: st_q <= ST_WAIT_PWR;
      endcase
    end
  end

  assign cmd_o        = cmd_q;
  assign cmd_stb_o    = stb_q;
  assign ba_o         = ba_q;
  assign addr_o       = addr_q;
  assign fifo_rst_o   = fifo_q;
  assign init_done_o  = done_q;
  assign refresh_en_o = ref_en_q;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_o,
  input logic       cmd_stb_o,
  input logic       fifo_rst_o,
  input logic       init_done_o,
  input logic       refresh_en_o
);
  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o && !init_done_o |-> cmd_o inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6});

  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o && !init_done_o |=> !cmd_stb_o);

  a_r7_idle_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb_o && !init_done_o |-> cmd_o == 3'd1);

  a_r8_fifo_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |=> !fifo_rst_o);

  a_r9_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o && refresh_en_o);

  a_r9_done_after_fifo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(fifo_rst_o));

  a_r11_idle_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o && !cmd_stb_o |-> cmd_o == 3'd7);
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_o        (cmd_o),
  .cmd_stb_o    (cmd_stb_o),
  .fifo_rst_o   (fifo_rst_o),
  .init_done_o  (init_done_o),
  .refresh_en_o (refresh_en_o)
);

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;
  localparam int ADDR_W = 13;
  localparam int GAP    = 2;
  localparam int N_SEQ  = 14;

  // {cmd, ba, addr}
  localparam logic [17:0] EXP_SEQ [0:N_SEQ-1] = '{
    {3'd1, 2'd0, 13'h000}, {3'd2, 2'd0, 13'h400}, {3'd4, 2'd1, 13'h000},
    {3'd3, 2'd0, 13'h12A}, {3'd2, 2'd0, 13'h400},
    {3'd6, 2'd0, 13'h000}, {3'd6, 2'd0, 13'h000}, {3'd6, 2'd0, 13'h000},
    {3'd6, 2'd0, 13'h000}, {3'd6, 2'd0, 13'h000}, {3'd6, 2'd0, 13'h000},
    {3'd6, 2'd0, 13'h000}, {3'd6, 2'd0, 13'h000}, {3'd3, 2'd0, 13'h02A}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic us_tick = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [1:0] req_ba = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0] cmd_o;
  logic cmd_stb_o;
  logic [1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;
  logic fifo_rst_o, init_done_o, refresh_en_o;

  int total = 0, bad = 0;
  int cyc = 0, tick_total = 0, tick_div = 0;
  int n_ev = 0, fifo_cnt = 0, fifo_cyc = -1, done_cyc = -1;
  logic [17:0] ev_val [0:31];
  int ev_cyc [0:31];
  int ev_tick [0:31];
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_init_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .us_tick_i(us_tick),
    .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_ba_i(req_ba), .req_addr_i(req_addr),
    .cmd_o(cmd_o), .cmd_stb_o(cmd_stb_o), .ba_o(ba_o), .addr_o(addr_o),
    .fifo_rst_o(fifo_rst_o), .init_done_o(init_done_o), .refresh_en_o(refresh_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string req);
    chk(cmd_o == 3'd1, req, cmd_o, 1);
    chk(cmd_stb_o == 1'b0 && fifo_rst_o == 1'b0, req, {cmd_stb_o, fifo_rst_o}, 0);
    chk(addr_o == '0 && ba_o == '0, req, addr_o, 0);
    chk(init_done_o == 1'b0 && refresh_en_o == 1'b0, req, {init_done_o, refresh_en_o}, 0);
  endtask

  // monitor and tick source: sample first, then drive
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_ni) tick_total = 0;
      if (rst_ni && cmd_stb_o && !init_done_o && n_ev < 32) begin
        ev_val[n_ev]  = {cmd_o, ba_o, addr_o};
        ev_cyc[n_ev]  = cyc;
        ev_tick[n_ev] = tick_total;
        n_ev++;
      end
      if (rst_ni && fifo_rst_o) begin fifo_cnt++; fifo_cyc = cyc; end
      if (rst_ni && init_done_o && done_cyc < 0) done_cyc = cyc;
      tick_div = (tick_div + 1) % 4;
      us_tick = (tick_div == 0);
      if (us_tick) tick_total++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("R1 reset");
    @(negedge clk); #1 rst_ni = 1'b1;

    // R10: requests throughout the sequence must be dropped
    forever begin
      @(negedge clk);
      if (init_done_o) break;
      req_valid = (cyc % 5 == 0);
      req_cmd   = 3'd3;
      req_ba    = 2'd2;
      req_addr  = 13'h1FF;
    end
    req_valid = 1'b0;

    chk(n_ev == N_SEQ, "R10 R4 strobe count", n_ev, N_SEQ);
    for (int i = 0; i < N_SEQ; i++) begin
      if (i < n_ev)
        chk(ev_val[i] == EXP_SEQ[i], "R4 R5 R2 command table", ev_val[i], EXP_SEQ[i]);
    end
    if (n_ev >= N_SEQ) begin
      chk(ev_tick[0] == 200, "R3 power-up ticks", ev_tick[0], 200);
      chk((ev_tick[4] - ev_tick[3]) >= 200 && (ev_tick[4] - ev_tick[3]) <= 201,
          "R6 DLL wait ticks", ev_tick[4] - ev_tick[3], 200);
      chk((ev_tick[13] - ev_tick[3]) >= 200, "R6 DLL to final MRS", ev_tick[13] - ev_tick[3], 200);
      for (int i = 0; i < N_SEQ - 1; i++) begin
        if (i != 3)
          chk(ev_cyc[i+1] - ev_cyc[i] == GAP + 1, "R7 command gap",
              ev_cyc[i+1] - ev_cyc[i], GAP + 1);
      end
      chk(fifo_cnt == 1, "R8 fifo pulse width", fifo_cnt, 1);
      chk(fifo_cyc == ev_cyc[13] + GAP + 1, "R8 fifo pulse cycle", fifo_cyc, ev_cyc[13] + GAP + 1);
      chk(done_cyc == ev_cyc[13] + GAP + 2, "R9 done cycle", done_cyc, ev_cyc[13] + GAP + 2);
    end
    chk(refresh_en_o == 1'b1, "R9 refresh enable", refresh_en_o, 1);
    chk(cmd_o == 3'd7 && cmd_stb_o == 1'b0, "R11 idle normal", cmd_o, 7);

    // R11 pass-through
    req_valid = 1'b1; req_cmd = 3'd2; req_ba = 2'd3; req_addr = 13'h400;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_stb_o == 1'b1 && cmd_o == 3'd2, "R11 forward cmd", {cmd_stb_o, cmd_o}, 4'hA);
    chk(addr_o == 13'h400 && ba_o == 2'd3, "R11 forward addr", addr_o, 13'h400);
    @(negedge clk);
    chk(cmd_stb_o == 1'b0 && cmd_o == 3'd7, "R11 back to idle", {cmd_stb_o, cmd_o}, 4'h7);

    repeat (20) @(negedge clk);
    chk(init_done_o && refresh_en_o, "R9 hold", {init_done_o, refresh_en_o}, 3);
    chk(fifo_cnt == 1, "R8 no second pulse", fifo_cnt, 1);

    #1 rst_ni = 1'b0;
    @(negedge clk);
    chk_reset_state("R1 re-reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule